// File: doc/BRIEF.md
# Training Pattern Bit Aligner

This block brings a received training bit stream into step with the pattern the receiver expects. Once the two are aligned, later decision-directed adaptation compares each received bit with the bit that was actually sent. The block runs in two passes.

In the first pass the link sends a step: a run of zeros, then 32 ones. The block counts bits until the first rising edge. Channel loss can make that edge show up late, so its position only bounds the answer. It sets the upper end of a small window of candidate delays, and the lower end lies a fixed margin below it.

In the second pass the link repeats a 128-bit pseudo-random pattern. For each candidate in the window, the block drives the external variable-delay selector to that value and counts the mismatches over one full pattern period. It keeps the candidate with the fewest mismatches. The winner is reported with its error count and left on the selector, so the alignment works even when residual inter-symbol interference leaves some errors at the best setting.

Top module: `bit_aligner`

## Requirements
- R1: After reset, `done_o` is 0 and `dly_sel_o`, `best_dly_o` and `best_err_o` are all 0.
- R2: A `start_i` pulse while the block is idle begins the coarse pass and drives `dly_sel_o` to 0 on the following cycle. A `start_i` pulse during a run has no effect on that run's results.
- R3: In the coarse pass, the edge is the first valid 1 that follows at least one valid 0. Ones that come before any zero are not taken as the edge. The edge position E is the number of valid bits accepted before the edge bit, saturating at 127.
- R4: After the edge bit, the next 31 valid bits are skipped. The valid bit after those carries expected-pattern index 0. The index advances by one on every valid bit of the fine pass and wraps from 127 to 0. Expected bit k is bit k of the `PATTERN` parameter, with bit 0 as the LSB.
- R5: The candidates run in ascending order from max(E-4, 0) to E. `dly_sel_o` takes the lowest candidate on the cycle after the edge bit, and each later candidate on the cycle after the previous candidate's last bit.
- R6: For each candidate, the first 2 valid bits are settling bits and are not counted. The next 128 valid bits are compared with the expected bits. Each bit that differs adds one to that candidate's error count, which never exceeds 128.
- R7: The reported delay is the candidate with the smallest error count. When counts are equal, the earlier (lower) candidate is kept.
- R8: `done_o` is a one-cycle pulse in the cycle after the final counted bit of the last candidate. In that cycle `best_dly_o`, `best_err_o` and `dly_sel_o` show the winner. `best_dly_o` and `best_err_o` change only when `done_o` is high.
- R9: A cycle with `bit_vld_i` low is ignored in every pass: it counts no bit, moves no pointer and cannot form the edge, whatever the value of `bit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an alignment run (accepted only when idle) |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Received bit after the variable delay selector |
| dly_sel_o | output | 7 | Setting of the external variable delay selector |
| done_o | output | 1 | One-cycle completion pulse |
| best_dly_o | output | 7 | Chosen delay of the last completed run |
| best_err_o | output | 8 | Mismatch count at the chosen delay |

## Verification
The bench places a clean match at the middle of the window, then repeats the test with deterministic bit errors spread over every candidate. This separates a true minimum search from a search for an error-free candidate. It moves the edge to force the window's lower clamp at 0 and to saturate the edge count at 127. It also puts ones ahead of the zeros to show that a 1 with no preceding 0 is not taken as the edge. A case with two equally clean delays tells the earlier-wins rule apart from a later-wins rule. A case with idle cycles carrying a 1, plus a stray start pulse in mid-sweep, shows that unqualified cycles and busy starts leave the result unchanged.

// File: rtl/aln_pkg.sv
package aln_pkg;

    localparam int PAT_LEN_D  = 128;
    localparam int DLY_W_D    = 7;
    localparam int MARGIN_D   = 4;
    localparam int ONES_RUN_D = 32;
    localparam int SETTLE_D   = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COARSE,
        ST_SKIP,
        ST_SWEEP
    } aln_state_e;

    // one received beat
    typedef struct packed {
        logic vld;
        logic val;
    } rx_beat_t;

    // default expected pattern: 7-stage LFSR (x^7 + x^6 + 1), 128 bits
    function automatic logic [PAT_LEN_D-1:0] gen_prbs();
        logic [PAT_LEN_D-1:0] seq;
        logic [6:0]           lfsr;
        logic                 fb;
        lfsr = 7'h7F;
        seq  = '0;
        for (int i = 0; i < PAT_LEN_D; i++) begin
            seq[i] = lfsr[6];
            fb     = lfsr[6] ^ lfsr[5];
            lfsr   = {lfsr[5:0], fb};
        end
        return seq;
    endfunction

    // low end of the fine window, clamped at zero
    function automatic int win_low(int edge_pos, int margin);
        return (edge_pos > margin) ? edge_pos - margin : 0;
    endfunction

endpackage

// File: rtl/aln_edge_finder.sv
module aln_edge_finder
    import aln_pkg::*;
#(
    parameter int DLY_W = DLY_W_D
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  rx_beat_t         rx,
    output logic             hit,
    output logic [DLY_W-1:0] pos
);
    logic             seen_zero;
    logic [DLY_W-1:0] cnt;

    assign hit = en && rx.vld && rx.val && seen_zero;
    assign pos = cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen_zero <= 1'b0;
            cnt       <= '0;
        end else if (en && rx.vld && !hit) begin
            if (cnt != {DLY_W{1'b1}})
                cnt <= cnt + DLY_W'(1);
            if (!rx.val)
                seen_zero <= 1'b1;
        end
    end
endmodule

// File: rtl/aln_pattern_src.sv
module aln_pattern_src
    import aln_pkg::*;
#(
    parameter int                 PAT_LEN = PAT_LEN_D,
    parameter logic [PAT_LEN-1:0] PATTERN = gen_prbs(),
    localparam int                PTR_W   = $clog2(PAT_LEN)
)(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic exp_bit
);
    logic [PTR_W-1:0] ptr;

    assign exp_bit = PATTERN[ptr];

    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == PTR_W'(PAT_LEN - 1)) ? '0 : ptr + PTR_W'(1);
    end
endmodule

// File: rtl/aln_mismatch_acc.sv
module aln_mismatch_acc
    import aln_pkg::*;
#(
    parameter int  PAT_LEN = PAT_LEN_D,
    parameter int  SETTLE  = SETTLE_D,
    localparam int ERR_W   = $clog2(PAT_LEN + 1),
    localparam int SPAN    = SETTLE + PAT_LEN,
    localparam int IDX_W   = $clog2(SPAN)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             mism,
    output logic             last,
    output logic [ERR_W-1:0] cand_err
);
    logic [IDX_W-1:0] idx;
    logic [ERR_W-1:0] acc;
    logic             counted;

    generate
        if (SETTLE == 0) begin : g_no_settle
            assign counted = 1'b1;
        end else begin : g_settle
            assign counted = (idx >= IDX_W'(SETTLE));
        end
    endgenerate

    assign last     = en && (idx == IDX_W'(SPAN - 1));
    assign cand_err = acc + ERR_W'(counted && mism);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
            acc <= '0;
        end else if (en) begin
            if (last) begin
                idx <= '0;
                acc <= '0;
            end else begin
                idx <= idx + IDX_W'(1);
                acc <= cand_err;
            end
        end
    end
endmodule

// File: rtl/aln_min_keeper.sv
module aln_min_keeper
    import aln_pkg::*;
#(
    parameter int DLY_W = DLY_W_D,
    parameter int ERR_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic [DLY_W-1:0] cand,
    input  logic [ERR_W-1:0] cand_err,
    output logic [DLY_W-1:0] win_dly,
    output logic [ERR_W-1:0] win_err
);
    logic [DLY_W-1:0] keep_dly;
    logic [ERR_W-1:0] keep_err;
    logic             better;

    // strict compare: on a tie the earlier candidate stays
    assign better  = upd && (cand_err < keep_err);
    assign win_dly = better ? cand : keep_dly;
    assign win_err = better ? cand_err : keep_err;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            keep_dly <= '0;
            keep_err <= '1;
        end else if (better) begin
            keep_dly <= cand;
            keep_err <= cand_err;
        end
    end
endmodule

// File: rtl/bit_aligner.sv
module bit_aligner
    import aln_pkg::*;
#(
    parameter int                 PAT_LEN  = PAT_LEN_D,
    parameter int                 DLY_W    = DLY_W_D,
    parameter int                 MARGIN   = MARGIN_D,
    parameter int                 ONES_RUN = ONES_RUN_D,
    parameter int                 SETTLE   = SETTLE_D,
    parameter logic [PAT_LEN-1:0] PATTERN  = gen_prbs(),
    localparam int                ERR_W    = $clog2(PAT_LEN + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    output logic [DLY_W-1:0] dly_sel_o,
    output logic             done_o,
    output logic [DLY_W-1:0] best_dly_o,
    output logic [ERR_W-1:0] best_err_o
);
    localparam int SKIP_N    = ONES_RUN - 1;
    localparam int SKIP_W    = $clog2(ONES_RUN + 1);
    localparam int SKIP_LAST = (SKIP_N > 0) ? SKIP_N - 1 : 0;

    aln_state_e       state;
    rx_beat_t         rx;
    logic [DLY_W-1:0] cand;
    logic [DLY_W-1:0] hi_q;
    logic [SKIP_W-1:0] skip_cnt;

    logic             start_ok;
    logic             edge_hit;
    logic [DLY_W-1:0] edge_pos;
    logic [DLY_W-1:0] lo_new;
    logic             sweep_en;
    logic             sweep_go;
    logic             exp_bit;
    logic             acc_last;
    logic [ERR_W-1:0] cand_err;
    logic [DLY_W-1:0] win_dly;
    logic [ERR_W-1:0] win_err;

    assign rx       = '{vld: bit_vld_i, val: bit_i};
    assign start_ok = (state == ST_IDLE) && start_i;
    assign lo_new   = DLY_W'(win_low(int'(edge_pos), MARGIN));
    assign sweep_en = (state == ST_SWEEP) && rx.vld;
    assign sweep_go = ((state == ST_COARSE) && edge_hit && (SKIP_N == 0)) ||
                      ((state == ST_SKIP) && rx.vld &&
                       (skip_cnt == SKIP_W'(SKIP_LAST)));

    aln_edge_finder #(
        .DLY_W (DLY_W)
    ) u_edge (
        .clk (clk),
        .rst (rst),
        .clr (start_ok),
        .en  (state == ST_COARSE),
        .rx  (rx),
        .hit (edge_hit),
        .pos (edge_pos)
    );

    aln_pattern_src #(
        .PAT_LEN (PAT_LEN),
        .PATTERN (PATTERN)
    ) u_pat (
        .clk     (clk),
        .rst     (rst),
        .clr     (sweep_go),
        .adv     (sweep_en),
        .exp_bit (exp_bit)
    );

    aln_mismatch_acc #(
        .PAT_LEN (PAT_LEN),
        .SETTLE  (SETTLE)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr      (sweep_go),
        .en       (sweep_en),
        .mism     (rx.val ^ exp_bit),
        .last     (acc_last),
        .cand_err (cand_err)
    );

    aln_min_keeper #(
        .DLY_W (DLY_W),
        .ERR_W (ERR_W)
    ) u_min (
        .clk      (clk),
        .rst      (rst),
        .clr      (sweep_go),
        .upd      (acc_last),
        .cand     (cand),
        .cand_err (cand_err),
        .win_dly  (win_dly),
        .win_err  (win_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dly_sel_o  <= '0;
            done_o     <= 1'b0;
            best_dly_o <= '0;
            best_err_o <= '0;
            cand       <= '0;
            hi_q       <= '0;
            skip_cnt   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state     <= ST_COARSE;
                        dly_sel_o <= '0;
                    end
                end
                ST_COARSE: begin
                    if (edge_hit) begin
                        cand      <= lo_new;
                        hi_q      <= edge_pos;
                        dly_sel_o <= lo_new;
                        skip_cnt  <= '0;
                        state     <= (SKIP_N == 0) ? ST_SWEEP : ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    if (rx.vld) begin
                        if (sweep_go)
                            state <= ST_SWEEP;
                        else
                            skip_cnt <= skip_cnt + SKIP_W'(1);
                    end
                end
                ST_SWEEP: begin
                    if (acc_last) begin
                        if (cand == hi_q) begin
                            state      <= ST_IDLE;
                            done_o     <= 1'b1;
                            best_dly_o <= win_dly;
                            best_err_o <= win_err;
                            dly_sel_o  <= win_dly;
                        end else begin
                            cand      <= cand + DLY_W'(1);
                            dly_sel_o <= cand + DLY_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aln_checker.sv
module aln_checker #(
    parameter int PAT_LEN = 128,
    parameter int DLY_W   = 7,
    parameter int ERR_W   = 8
)(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             bit_vld_i,
    input logic             done_o,
    input logic [DLY_W-1:0] dly_sel_o,
    input logic [DLY_W-1:0] best_dly_o,
    input logic [ERR_W-1:0] best_err_o
);
    // R8: completion lasts exactly one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: selector carries the winner at completion
    assert_winner_on_sel_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (dly_sel_o == best_dly_o));

    // R6: a count never exceeds one pattern period
    assert_err_bound_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (best_err_o <= ERR_W'(PAT_LEN)));

    // R9: an unqualified cycle without start moves nothing
    assert_idle_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld_i && !start_i) |=> ($stable(dly_sel_o) && !done_o));

    // R8: results change only together with completion
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ((best_dly_o != $past(best_dly_o)) || (best_err_o != $past(best_err_o)))
        |-> done_o);
endmodule

bind bit_aligner aln_checker #(
    .PAT_LEN (PAT_LEN),
    .DLY_W   (DLY_W),
    .ERR_W   (ERR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .bit_vld_i  (bit_vld_i),
    .done_o     (done_o),
    .dly_sel_o  (dly_sel_o),
    .best_dly_o (best_dly_o),
    .best_err_o (best_err_o)
);

// File: tb/bit_aligner_test.sv
module bit_aligner_test;
    localparam int PL  = 128;
    localparam int DW  = 7;
    localparam int MG  = 4;
    localparam int RUN = 32;
    localparam int ST  = 2;
    localparam logic [PL-1:0] PAT = 128'h9C3E_51A7_0BD4_F286_6E1B_C953_28AF_7D40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          bit_vld_i = 1'b0;
    logic          bit_i = 1'b0;
    logic [DW-1:0] dly_sel_o;
    logic          done_o;
    logic [DW-1:0] best_dly_o;
    logic [7:0]    best_err_o;

    always #5 clk = ~clk;

    bit_aligner #(
        .PAT_LEN  (PL),
        .DLY_W    (DW),
        .MARGIN   (MG),
        .ONES_RUN (RUN),
        .SETTLE   (ST),
        .PATTERN  (PAT)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bit_vld_i  (bit_vld_i),
        .bit_i      (bit_i),
        .dly_sel_o  (dly_sel_o),
        .done_o     (done_o),
        .best_dly_o (best_dly_o),
        .best_err_o (best_err_o)
    );

    typedef struct {
        int dly;
        int err;
        int lo;
        int hi;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   sc_t, sc_t2, sc_noise;
    bit   running = 1'b0;
    int   prev_sel, chg;
    int   last_dly = 0;
    int   last_err = 0;
    int   gcnt = 0;

    task automatic check(string req, string what, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // channel model: aligned candidates see the pattern unshifted
    function automatic int chan(int p, int d);
        int sh, idx, b;
        sh  = (d == sc_t || d == sc_t2) ? 0 : d - sc_t;
        idx = ((p + sh) % PL + PL) % PL;
        b   = int'(PAT[idx]);
        if (sc_noise > 0 && ((p * 7 + d * 3) % sc_noise) == 0)
            b = b ^ 1;
        return b;
    endfunction

    // monitor: pops expected results on completion
    always @(negedge clk) begin
        exp_t e;
        if (running && !rst) begin
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    check("R8", "unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check("R7", "best delay", int'(best_dly_o), e.dly);
                    check("R6", "best error count", int'(best_err_o), e.err);
                    check("R8", "selector at done", int'(dly_sel_o), e.dly);
                    check("R5", "last candidate", prev_sel, e.hi);
                    check("R5", "selector steps", chg,
                          ((e.lo != 0) ? 1 : 0) + (e.hi - e.lo));
                end
                running = 1'b0;
            end else begin
                if (int'(dly_sel_o) != prev_sel)
                    chg++;
                prev_sel = int'(dly_sel_o);
            end
        end
    end

    task automatic send(bit v, bit b);
        bit_vld_i = v;
        bit_i     = b;
        @(negedge clk);
    endtask

    task automatic send_data(bit gaps, bit b);
        if (gaps && (gcnt % 3 == 2))
            send(1'b0, 1'b1);
        gcnt++;
        send(1'b1, b);
    endtask

    task automatic run_case(int lead1, int zeros, int t, int t2, int noise,
                            bit gaps, bit poke);
        exp_t e;
        int   edge_e, best, p, err, base;
        sc_t = t; sc_t2 = t2; sc_noise = noise;
        edge_e = lead1 + zeros;
        if (edge_e > 127) edge_e = 127;
        e.hi  = edge_e;
        e.lo  = (edge_e > MG) ? edge_e - MG : 0;
        best  = 1 << 30;
        e.dly = e.lo;
        for (int d = e.lo; d <= e.hi; d++) begin
            base = (d - e.lo) * (ST + PL);
            err  = 0;
            for (int k = 0; k < PL; k++) begin
                p = base + ST + k;
                if (chan(p, d) != int'(PAT[p % PL]))
                    err++;
            end
            if (err < best) begin
                best  = err;
                e.dly = d;
            end
        end
        e.err = best;
        sb_q.push_back(e);

        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "selector after start", int'(dly_sel_o), 0);
        check("R8", "held delay", int'(best_dly_o), last_dly);
        check("R8", "held error", int'(best_err_o), last_err);
        prev_sel = 0;
        chg      = 0;
        running  = 1'b1;
        gcnt     = 0;

        for (int i = 0; i < lead1; i++) send_data(gaps, 1'b1);
        for (int i = 0; i < zeros; i++) send_data(gaps, 1'b0);
        for (int i = 0; i < RUN; i++) send_data(gaps, 1'b1);

        p = 0;
        while (done_o !== 1'b1) begin
            start_i = (poke && p == 150) ? 1'b1 : 1'b0;
            if (gaps && (gcnt % 3 == 2)) begin
                send(1'b0, 1'b1);
            end else begin
                send(1'b1, 1'(chan(p, int'(dly_sel_o))));
                p++;
            end
            gcnt++;
        end
        start_i = 1'b0;
        send(1'b0, 1'b0);
        check("R8", "done pulse width", int'(done_o), 0);
        // bits while idle must not disturb anything (R9)
        send(1'b1, 1'b1);
        send(1'b1, 1'b0);
        check("R9", "idle done", int'(done_o), 0);
        check("R9", "idle selector", int'(dly_sel_o), e.dly);
        check("R8", "result held", int'(best_dly_o), e.dly);
        last_dly = e.dly;
        last_err = e.err;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset done", int'(done_o), 0);
        check("R1", "reset selector", int'(dly_sel_o), 0);
        check("R1", "reset delay", int'(best_dly_o), 0);
        check("R1", "reset error", int'(best_err_o), 0);

        run_case(0, 20, 18, -1, 0, 1'b0, 1'b0);   // R7 clean mid-window
        run_case(0, 40, 37, -1, 11, 1'b0, 1'b0);  // R6 errors on every candidate
        run_case(3, 10, 9, -1, 0, 1'b0, 1'b0);    // R3 leading ones, R4 low end
        run_case(0, 2, 0, -1, 0, 1'b0, 1'b0);     // R5 clamp at zero
        run_case(0, 200, 127, -1, 0, 1'b0, 1'b0); // R3 saturation at 127
        run_case(0, 30, 27, 29, 0, 1'b0, 1'b0);   // R7 tie keeps earlier
        run_case(0, 25, 22, -1, 17, 1'b1, 1'b1);  // R9 gaps, R2 busy start
        finish_run();
    end
endmodule